// File: doc/BRIEF.md
# Self-Restarting Serial Link Supervisor

This block watches over a full-duplex packet link between two chips. The far chip is a slave, clocked and selected by the near chip, which is the master. One side (`m_*`) runs on the master chip and drives the active-low select line. The other side (`s_*`) runs on the slave chip and listens to that line. The bit shifting and the single-correct/double-detect and checksum logic sit outside the block. Each side sees them only as a packet-complete strobe and an error flag that is qualified by that strobe. A packet is 128 bits long and the serial clock is one quarter of the system clock, so a healthy packet arrives at least every 512 system clocks.

The select line is the only path that carries a reset between the two sides. The master has a receive-stall timer of 556 cycles by default. When that timer expires, or a packet arrives marked uncorrectable, the master drops into a hold phase. During hold it resets its own engine and its receive and transmit processes, and it keeps select inactive for a settling period (`HOLDOFF`). After that it selects the slave again. When the slave sees a bad packet or its own stall timeout, it freezes: it stops taking part in transfers and waits. The master then hits its own timeout and restarts through the same hold path. The slave resets its processes whenever select is inactive and rejoins when select returns. It counts every such rejoin in a saturating 16-bit counter that is meant for a four-digit hex display.

Received packets reach the peripheral side only through the `*_pkt_ok` strobes. These pulse for one cycle for a packet that completes while its side is running and carries no uncorrectable error. The link cannot pause, so these strobes carry no ready or back-pressure: a consumer must take each pulse in the cycle it appears. Both sides are modelled here on one clock, and select crosses to the slave through a `SYNC_STAGES` synchroniser. `HOLDOFF` must be longer than the slave's reset latency of `SYNC_STAGES`+1 cycles.

Top module: `link_restart_sup`

## Requirements
- R1: From the release of `m_rst_n`, and whenever `m_rst_n` is low, `ss_n` and `m_proc_rst` are 1. They stay at 1 for exactly `HOLDOFF` (64) cycles after release, and then both go to 0.
- R2: While the master is running (`ss_n` = 0), a span of `M_TIMEOUT` (556) consecutive cycles with no `m_pkt_done` returns it to hold: `ss_n` = 1 and `m_proc_rst` = 1 for `HOLDOFF` cycles. It then runs again. Packets spaced at most every 100 cycles never cause this.
- R3: `m_pkt_done` together with `m_pkt_err` while the master is running puts `ss_n` and `m_proc_rst` at 1 from the next cycle, for `HOLDOFF` cycles.
- R4: `m_pkt_ok` is 1 exactly in cycles where the master is running, `m_pkt_done` is 1 and `m_pkt_err` is 0. `s_pkt_ok` is 1 exactly when the slave is running (not reset, not frozen), `s_pkt_done` is 1 and `s_pkt_err` is 0.
- R5: `s_proc_rst` is 1 while `s_rst_n` is low and from `SYNC_STAGES`+1 (3) cycles after `ss_n` rises. It goes to 0 exactly `SYNC_STAGES`+1 cycles after `ss_n` falls.
- R6: `s_pkt_done` with `s_pkt_err` while the slave is running sets `s_frozen` to 1 from the next cycle. `s_pkt_ok` stays 0 for every packet that completes while frozen.
- R7: While the slave is running, `M_TIMEOUT`-independent `S_TIMEOUT` (556) consecutive cycles with no `s_pkt_done` set `s_frozen`.
- R8: Once frozen, the slave stays frozen with `s_proc_rst` = 0 for as long as `ss_n` stays 0. After `ss_n` rises it leaves the frozen state with `s_proc_rst` = 1, `SYNC_STAGES`+1 cycles later.
- R9: `s_restart_cnt` is 0 after `s_rst_n`. It rises by exactly one each time the slave re-enters the running state, except on the first entry after `s_rst_n`. It saturates at 16'hFFFF and does not change when `m_rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| m_rst_n | input | 1 | Master power-on reset, active low, asynchronous |
| s_rst_n | input | 1 | Slave power-on reset, active low, asynchronous |
| m_pkt_done | input | 1 | Master: a received packet completed this cycle |
| m_pkt_err | input | 1 | Master: that packet has an uncorrectable error |
| s_pkt_done | input | 1 | Slave: a received packet completed this cycle |
| s_pkt_err | input | 1 | Slave: that packet has an uncorrectable error |
| ss_n | output | 1 | Slave select driven by the master, active low |
| m_proc_rst | output | 1 | Master reset for serial engine, receive and transmit processes |
| m_pkt_ok | output | 1 | Master: pass received packet to peripheral signals |
| s_proc_rst | output | 1 | Slave reset for serial engine, receive and transmit processes |
| s_frozen | output | 1 | Slave has stopped taking part in transfers |
| s_pkt_ok | output | 1 | Slave: pass received packet to peripheral signals |
| s_restart_cnt | output | 16 | Saturating count of slave rejoins |

## Verification
On every cycle, the embedded properties check four things. An error packet forces the next state on each side (hold on the master, frozen on the slave). A good packet is never followed by hold. A frozen slave stays frozen while select is active. The restart counter only ever steps by one and sticks at its maximum. A loss of select is also always followed by a slave reset. The exact lengths of hold and stall windows, the synchroniser delay on the slave, and the full recovery sequences can only be shown by the directed scenarios. Those sequences are: slave freezes, then the master times out, then the slave rejoins; and a master power-on reset in the middle of traffic. The same holds for the counter's behaviour across a master reset versus a slave reset. Saturation of the counter is reached only by the property, since 65535 restarts lie beyond a directed run.

// File: rtl/link_sup_pkg.sv
package link_sup_pkg;
  typedef enum logic {
    M_HOLD = 1'b0,
    M_RUN  = 1'b1
  } m_state_t;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_RUN    = 2'd1,
    S_FROZEN = 2'd2
  } s_state_t;
endpackage

// File: rtl/cyc_timer.sv
// Counts enabled cycles; done pulses in the LIMIT-th consecutive enabled
// cycle without a clear. Returns to zero whenever disabled or cleared.
module cyc_timer #(
  parameter int LIMIT = 556
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic done
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || clr) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + W'(1);
  end

  assign done = en && !clr && (cnt == LAST);
endmodule

// File: rtl/ss_sync.sv
// Brings the select line into the slave's clock domain; resets to inactive.
module ss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_n_in,
  output logic ss_act
);
  logic [STAGES-1:0] q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[0] <= 1'b1;
        else        q[0] <= ss_n_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[i] <= 1'b1;
        else        q[i] <= q[i-1];
      end
    end
  end

  assign ss_act = ~q[STAGES-1];
endmodule

// File: rtl/master_sup.sv
module master_sup
  import link_sup_pkg::*;
#(
  parameter int TIMEOUT = 556,
  parameter int HOLDOFF = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pkt_done,
  input  logic pkt_err,
  output logic ss_n,
  output logic proc_rst,
  output logic pkt_ok
);
  m_state_t st;
  logic     hold_done, stall_done, running;

  assign running = (st == M_RUN);

  cyc_timer #(.LIMIT(HOLDOFF)) u_hold (
    .clk(clk), .rst_n(rst_n), .en(!running), .clr(1'b0), .done(hold_done)
  );

  cyc_timer #(.LIMIT(TIMEOUT)) u_stall (
    .clk(clk), .rst_n(rst_n), .en(running), .clr(pkt_done), .done(stall_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= M_HOLD;
    else begin
      case (st)
        M_HOLD:  if (hold_done) st <= M_RUN;
        default: if ((pkt_done && pkt_err) || stall_done) st <= M_HOLD;
      endcase
    end
  end

  assign ss_n     = !running;
  assign proc_rst = !running;
  assign pkt_ok   = running && pkt_done && !pkt_err;

  // R3: an error packet while running sends the master to hold next cycle
  a_r3_err_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pkt_done && pkt_err) |=> ss_n);

  // R2: a good packet is never followed by a drop of select
  a_r2_ok_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ok |=> !ss_n);

  // R1: select is only raised to active after the hold-off window ends
  a_r1_release_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> $past(hold_done));
endmodule

// File: rtl/slave_sup.sv
module slave_sup
  import link_sup_pkg::*;
#(
  parameter int TIMEOUT     = 556,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ss_n,
  input  logic             pkt_done,
  input  logic             pkt_err,
  output logic             proc_rst,
  output logic             frozen,
  output logic             pkt_ok,
  output logic [CNT_W-1:0] restart_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  s_state_t st;
  logic     ss_act, stall_done, running, seen_run;

  assign running = (st == S_RUN);

  ss_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ss_n_in(ss_n), .ss_act(ss_act)
  );

  cyc_timer #(.LIMIT(TIMEOUT)) u_stall (
    .clk(clk), .rst_n(rst_n), .en(running), .clr(pkt_done), .done(stall_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      seen_run    <= 1'b0;
      restart_cnt <= '0;
    end else if (!ss_act) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: begin
          st       <= S_RUN;
          seen_run <= 1'b1;
          if (seen_run && restart_cnt != CNT_MAX)
            restart_cnt <= restart_cnt + CNT_W'(1);
        end
        S_RUN:   if ((pkt_done && pkt_err) || stall_done) st <= S_FROZEN;
        default: st <= S_FROZEN;
      endcase
    end
  end

  assign proc_rst = (st == S_IDLE);
  assign frozen   = (st == S_FROZEN);
  assign pkt_ok   = running && pkt_done && !pkt_err;

  // R6: an error packet while running freezes the slave next cycle
  a_r6_err_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (running && ss_act && pkt_done && pkt_err) |=> frozen);

  // R8: the frozen state persists while select stays active
  a_r8_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && ss_act) |=> frozen);

  // R5: loss of select always resets the slave processes
  a_r5_drop_resets: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_act |=> proc_rst);

  // R9: counter sticks at its maximum
  a_r9_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_cnt == CNT_MAX) |=> (restart_cnt == CNT_MAX));

  // R9: counter only ever steps up by one
  a_r9_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_cnt != $past(restart_cnt)) |-> (restart_cnt == $past(restart_cnt) + CNT_W'(1)));
endmodule

// File: rtl/link_restart_sup.sv
module link_restart_sup #(
  parameter int M_TIMEOUT   = 556,
  parameter int S_TIMEOUT   = 556,
  parameter int HOLDOFF     = 64,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             m_rst_n,
  input  logic             s_rst_n,
  input  logic             m_pkt_done,
  input  logic             m_pkt_err,
  input  logic             s_pkt_done,
  input  logic             s_pkt_err,
  output logic             ss_n,
  output logic             m_proc_rst,
  output logic             m_pkt_ok,
  output logic             s_proc_rst,
  output logic             s_frozen,
  output logic             s_pkt_ok,
  output logic [CNT_W-1:0] s_restart_cnt
);
  master_sup #(.TIMEOUT(M_TIMEOUT), .HOLDOFF(HOLDOFF)) u_master (
    .clk(clk), .rst_n(m_rst_n), .pkt_done(m_pkt_done), .pkt_err(m_pkt_err),
    .ss_n(ss_n), .proc_rst(m_proc_rst), .pkt_ok(m_pkt_ok)
  );

  slave_sup #(.TIMEOUT(S_TIMEOUT), .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_slave (
    .clk(clk), .rst_n(s_rst_n), .ss_n(ss_n), .pkt_done(s_pkt_done),
    .pkt_err(s_pkt_err), .proc_rst(s_proc_rst), .frozen(s_frozen),
    .pkt_ok(s_pkt_ok), .restart_cnt(s_restart_cnt)
  );
endmodule

// File: tb/sim_link_restart_sup.sv
`timescale 1ns/1ps
module sim_link_restart_sup;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic m_rst_n, s_rst_n, m_man, s_man, m_err, s_err;
  logic fm, fs, feed_m, feed_s;
  logic ss_n, m_proc_rst, m_pkt_ok, s_proc_rst, s_frozen, s_pkt_ok;
  logic [15:0] s_restart_cnt;
  int checks = 0, fails = 0, exp_cnt = 0, tick = 0;

  link_restart_sup u0 (
    .clk(clk), .m_rst_n(m_rst_n), .s_rst_n(s_rst_n),
    .m_pkt_done(m_man | fm), .m_pkt_err(m_err),
    .s_pkt_done(s_man | fs), .s_pkt_err(s_err),
    .ss_n(ss_n), .m_proc_rst(m_proc_rst), .m_pkt_ok(m_pkt_ok),
    .s_proc_rst(s_proc_rst), .s_frozen(s_frozen), .s_pkt_ok(s_pkt_ok),
    .s_restart_cnt(s_restart_cnt)
  );

  // background packet source: one good packet every 100 cycles
  initial begin
    fm = 1'b0; fs = 1'b0;
    forever begin
      @(negedge clk);
      tick = (tick >= 99) ? 0 : tick + 1;
      fm = feed_m && (tick == 0);
      fs = feed_s && (tick == 0);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_len(input logic val, output int n);
    n = 0;
    while (ss_n === val && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_ss(input logic val);
    int k = 0;
    while (ss_n !== val && k < 2000) begin @(negedge clk); k++; end
  endtask

  // called at the first sample after select falls
  task automatic rejoin(input string tag);
    check({tag, " R5 slave still in reset"}, s_proc_rst, 1);
    repeat (3) @(negedge clk);
    exp_cnt++;
    check({tag, " R5 slave released"}, s_proc_rst, 0);
    check({tag, " R8 not frozen after rejoin"}, s_frozen, 0);
    check({tag, " R9 restart count"}, s_restart_cnt, exp_cnt);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    check("R1 reset ss_n", ss_n, 1);
    check("R1 reset m_proc_rst", m_proc_rst, 1);
    check("R5 reset s_proc_rst", s_proc_rst, 1);
    check("R9 reset count", s_restart_cnt, 0);
    check("R6 reset frozen", s_frozen, 0);
  endtask

  task automatic t_startup();
    int n;
    m_rst_n = 1'b1; s_rst_n = 1'b1;
    run_len(1'b1, n);
    check("R1 hold-off length", n, 64);
    check("R1 master released", m_proc_rst, 0);
    check("R5 slave reset at select", s_proc_rst, 1);
    repeat (2) @(negedge clk);
    check("R5 slave reset after 2", s_proc_rst, 1);
    @(negedge clk);
    check("R5 slave released after 3", s_proc_rst, 0);
    check("R9 first start not counted", s_restart_cnt, 0);
    feed_m = 1'b1; feed_s = 1'b1;
  endtask

  task automatic t_traffic();
    int okm = 0, oks = 0;
    feed_m = 1'b0; feed_s = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); m_man = 1'b1; s_man = 1'b1;
      #1; okm += m_pkt_ok; oks += s_pkt_ok;
      @(negedge clk); m_man = 1'b0; s_man = 1'b0;
      repeat (98) @(negedge clk);
    end
    check("R4 master good packets", okm, 10);
    check("R4 slave good packets", oks, 10);
    check("R2 no timeout under traffic", ss_n, 0);
    feed_m = 1'b1; feed_s = 1'b1;
  endtask

  task automatic t_master_err();
    int n;
    feed_m = 1'b0; feed_s = 1'b0;
    @(negedge clk); m_man = 1'b1; m_err = 1'b1;
    #1; check("R4 error packet not passed", m_pkt_ok, 0);
    @(negedge clk); m_man = 1'b0; m_err = 1'b0;
    check("R3 hold after error", ss_n, 1);
    check("R3 master reset after error", m_proc_rst, 1);
    run_len(1'b1, n);
    check("R3 hold length after error", n, 64);
    rejoin("master error");
    feed_m = 1'b1; feed_s = 1'b1;
  endtask

  task automatic t_slave_err();
    feed_m = 1'b0; feed_s = 1'b0;
    @(negedge clk); s_man = 1'b1; s_err = 1'b1;
    #1; check("R4 slave error packet not passed", s_pkt_ok, 0);
    @(negedge clk); s_man = 1'b0; s_err = 1'b0;
    check("R6 frozen after error", s_frozen, 1);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      s_man = (i == 150);
      if (i == 150) begin #1; check("R6 no data while frozen", s_pkt_ok, 0); end
    end
    s_man = 1'b0;
    check("R8 still frozen", s_frozen, 1);
    check("R8 frozen not reset", s_proc_rst, 0);
    wait_ss(1'b1);
    check("R2 master timed out", ss_n, 1);
    repeat (3) @(negedge clk);
    check("R8 frozen cleared by drop", s_frozen, 0);
    check("R8 reset on drop", s_proc_rst, 1);
    wait_ss(1'b0);
    rejoin("slave error");
  endtask

  task automatic t_timeout();
    int n;
    wait_ss(1'b1);
    run_len(1'b1, n);
    check("R2 hold length after timeout", n, 64);
    run_len(1'b0, n);
    check("R2 run length without packets", n, 556);
    exp_cnt++;
    check("R9 count after timeout restart", s_restart_cnt, exp_cnt);
  endtask

  task automatic t_slave_timeout();
    int n = 0;
    feed_m = 1'b1; feed_s = 1'b0;
    wait_ss(1'b0);
    rejoin("slave timeout start");
    while (!s_frozen && n < 2000) begin @(negedge clk); n++; end
    check("R7 slave stall window", n, 556);
    check("R8 master still selects", ss_n, 0);
    feed_m = 1'b0;
    wait_ss(1'b1);
    wait_ss(1'b0);
    rejoin("slave timeout recovery");
  endtask

  task automatic t_master_por();
    int n;
    feed_m = 1'b1; feed_s = 1'b1;
    repeat (200) @(negedge clk);
    m_rst_n = 1'b0;
    #1;
    check("R1 select drops in reset", ss_n, 1);
    check("R1 master reset in reset", m_proc_rst, 1);
    repeat (10) @(negedge clk);
    check("R5 slave reset by master reset", s_proc_rst, 1);
    check("R9 count kept over master reset", s_restart_cnt, exp_cnt);
    m_rst_n = 1'b1;
    run_len(1'b1, n);
    check("R1 hold-off after master reset", n, 64);
    rejoin("master reset");
  endtask

  task automatic t_slave_por();
    @(negedge clk); s_rst_n = 1'b0;
    #1;
    check("R9 count cleared by slave reset", s_restart_cnt, 0);
    check("R5 slave reset asserted", s_proc_rst, 1);
    repeat (3) @(negedge clk);
    s_rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R5 slave rejoins active select", s_proc_rst, 0);
    check("R9 first run after slave reset not counted", s_restart_cnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    m_rst_n = 1'b0; s_rst_n = 1'b0;
    m_man = 1'b0; s_man = 1'b0; m_err = 1'b0; s_err = 1'b0;
    feed_m = 1'b0; feed_s = 1'b0;
    t_reset();
    t_startup();
    t_traffic();
    t_master_err();
    t_slave_err();
    t_timeout();
    t_slave_timeout();
    t_master_por();
    t_slave_por();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule